// File: doc/BRIEF.md
# UART Channel with Test-Mode Routing

This block is one serial channel: an 8-bit transmitter and an 8-bit receiver. Each frame has one start bit and one stop bit, and a parity bit can be added. The transmitter and the receiver each run from their own 16x oversample tick. A two-bit mode input picks how the serial pins, the host data path and the baud ticks connect. The four choices are normal operation, automatic echo, local loopback and remote loopback. The test modes let a link be checked from either end without external wiring.

In automatic echo, the line input is sent straight back out. The receiver still decodes the line and reports characters and errors to the host. In local loopback, the transmitter drives the receiver internally and the receiver runs from the transmit tick. In remote loopback, the line is copied onto the transmit pin one sample per receive tick, and the host sees nothing from the channel. In both echo-type modes the copy is raw, so parity, stop bits and break are passed on exactly as they arrive. The host side has a write strobe and a read strobe, one holding register in each direction, and status flags for the transmitter and the receiver.

Top module: `uart_mode_router`

## Requirements
- R1: The active mode is encoded as 0 normal, 1 automatic echo, 2 local loopback and 3 remote loopback. A new value on `mode_sel` takes effect only in a cycle where the transmit shifter and the receiver are both idle.
- R2: In normal mode, a host write while `tx_rdy` is 1 loads the holding register. `tx_rdy` then drops until the shifter takes the character. When `tx_en` is 1, the frame goes out as a 0 start bit, then data LSB first, then the optional parity bit, then a 1 stop bit, at 16 transmit ticks per bit. `tx_empty` is 1 only when the holding register and the shifter are both empty, and the idle line is 1.
- R3: When `par_en` is 1, a parity bit follows the data. With `par_odd` = 0 the data bits plus the parity bit hold an even number of ones; with `par_odd` = 1 they hold an odd number. A received character whose parity bit does not match raises `par_err` for that character.
- R4: The receiver accepts a start bit only if the line is still 0 at the 8th tick after the falling edge. It samples every later bit at its middle, so a low pulse shorter than half a bit produces no character.
- R5: A completed character sets `rx_rdy` and appears on `rx_data`. A host read clears `rx_rdy`. If a character completes while `rx_rdy` is still 1, `ovr_err` is set; a host read clears it.
- R6: If the stop bit is sampled as 0 and the frame is not a break, the character is delivered with `frm_err` = 1.
- R7: A frame that reads 0 in every bit, stop bit included, is a break. It sets `brk_flag` (cleared by a host read) and delivers no character. No further character is accepted until the line returns to 1.
- R8: In automatic echo mode, `line_tx` follows `line_rx` one clock later, break included. `tx_rdy` and `tx_empty` read 0, and host writes are ignored.
- R9: In automatic echo mode, the receiver still delivers characters to the host and still reports parity, framing and break.
- R10: In local loopback mode, `line_tx` stays at 1 and `line_rx` is ignored. The receiver takes the transmitter's output and runs from `tx_tick`, even when `rx_en` is 0. No character is looped while `tx_en` is 0.
- R11: In remote loopback mode, `line_tx` takes the value of `line_rx` at each `rx_tick` and holds it between ticks. Host writes are ignored, received frames are not delivered, and `tx_rdy`, `tx_empty`, `rx_rdy`, `par_err`, `frm_err`, `brk_flag` and `ovr_err` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Requested routing mode |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable (not needed in local loopback) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| tx_tick | input | 1 | 16x baud tick for the transmitter |
| rx_tick | input | 1 | 16x baud tick for the receiver |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Character to send |
| host_rd | input | 1 | Host read strobe; clears receive status |
| rx_data | output | 8 | Last received character |
| tx_rdy | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Transmitter fully drained |
| rx_rdy | output | 1 | Unread character available |
| par_err | output | 1 | Parity mismatch on the last character |
| frm_err | output | 1 | Stop bit was 0 on the last character |
| brk_flag | output | 1 | Break seen |
| ovr_err | output | 1 | Character completed while one was unread |
| line_rx | input | 1 | Serial line input |
| line_tx | output | 1 | Serial line output |

## Verification
The receiver is driven with clean frames, frames with correct and wrong parity, a frame with a bad stop bit, a short low glitch and a long break. These separate a good character from a parity error, a framing error, a rejected start bit and a break. The same serial traffic is then sent in each mode. In echo the character is still received but the host cannot transmit. In local loopback the external pin is ignored. In remote loopback nothing reaches the host. Single manually placed receive ticks show that remote loopback copies the line on the receive tick. A mode request made while the transmitter is busy shows that the switch waits for idle.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;

    localparam int CHAR_W = 8;
    localparam int OVS_RATE = 16;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_ECHO   = 2'd1,
        MODE_LOCAL  = 2'd2,
        MODE_REMOTE = 2'd3
    } chan_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRK
    } rx_state_e;

    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic brk;
        logic ovr;
    } rx_flags_t;

    function automatic logic parity_of(input logic [CHAR_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_mode_pkg::*;
#(
    parameter int DATA_W = CHAR_W,
    parameter int OVS    = OVS_RATE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              txd,
    output logic              thr_full,
    output logic              busy
);
    localparam int CW = $clog2(OVS);
    localparam int FW = DATA_W + 3;
    localparam int BW = $clog2(FW + 1);
    localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);

    logic [DATA_W-1:0] thr;
    logic [FW-1:0]     frame;
    logic [CW-1:0]     tcnt;
    logic [BW-1:0]     bcnt;
    logic [BW-1:0]     nbits;
    logic              pbit;

    assign nbits = par_en ? BW'(DATA_W + 3) : BW'(DATA_W + 2);
    assign pbit  = par_en ? parity_of(thr, par_odd) : 1'b1;
    assign txd   = frame[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            thr      <= '0;
            thr_full <= 1'b0;
            frame    <= '1;
            tcnt     <= '0;
            bcnt     <= '0;
            busy     <= 1'b0;
        end else begin
            if (wr && !thr_full) begin
                thr      <= wdata;
                thr_full <= 1'b1;
            end
            if (!busy) begin
                if (tick && en && thr_full) begin
                    frame    <= {1'b1, pbit, thr, 1'b0};
                    thr_full <= 1'b0;
                    busy     <= 1'b1;
                    tcnt     <= '0;
                    bcnt     <= '0;
                end
            end else if (tick) begin
                if (tcnt == T_LAST) begin
                    tcnt  <= '0;
                    frame <= {1'b1, frame[FW-1:1]};
                    if (bcnt == nbits - BW'(1)) busy <= 1'b0;
                    else                        bcnt <= bcnt + BW'(1);
                end else begin
                    tcnt <= tcnt + CW'(1);
                end
            end
        end
    end

    // R2: an idle shifter leaves the line marking
    assert_idle_mark_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R2: an accepted write fills the holding register
    assert_thr_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && !thr_full) |=> thr_full);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_mode_pkg::*;
#(
    parameter int DATA_W = CHAR_W,
    parameter int OVS    = OVS_RATE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    input  logic              rd,
    output logic              rdy,
    output logic [DATA_W-1:0] data,
    output rx_flags_t         flags,
    output logic              busy
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DATA_W);
    localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] T_MID  = CW'(OVS / 2 - 1);

    rx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     bidx;
    logic [DATA_W-1:0] sh;
    logic              pbit;
    logic              is_brk;

    assign busy   = (st != RX_IDLE);
    assign is_brk = !rxd && (sh == '0) && (!par_en || !pbit);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            sh    <= '0;
            pbit  <= 1'b0;
            rdy   <= 1'b0;
            data  <= '0;
            flags <= '0;
        end else begin
            if (rd) begin
                rdy       <= 1'b0;
                flags.ovr <= 1'b0;
                flags.brk <= 1'b0;
            end
            if (!run) begin
                st <= RX_IDLE;
            end else if (tick) begin
                case (st)
                    RX_IDLE: if (!rxd) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                    RX_START: if (cnt == T_MID) begin
                        st   <= rxd ? RX_IDLE : RX_DATA;
                        cnt  <= '0;
                        bidx <= '0;
                    end else cnt <= cnt + CW'(1);
                    RX_DATA: if (cnt == T_LAST) begin
                        cnt <= '0;
                        sh  <= {rxd, sh[DATA_W-1:1]};
                        if (bidx == IW'(DATA_W - 1)) st <= par_en ? RX_PAR : RX_STOP;
                        else                         bidx <= bidx + IW'(1);
                    end else cnt <= cnt + CW'(1);
                    RX_PAR: if (cnt == T_LAST) begin
                        cnt  <= '0;
                        pbit <= rxd;
                        st   <= RX_STOP;
                    end else cnt <= cnt + CW'(1);
                    RX_STOP: if (cnt == T_LAST) begin
                        cnt <= '0;
                        if (is_brk) begin
                            flags.brk <= 1'b1;
                            st        <= RX_BRK;
                        end else begin
                            data          <= sh;
                            rdy           <= 1'b1;
                            flags.ovr     <= (rdy && !rd) | (flags.ovr && !rd);
                            flags.par_err <= par_en && (pbit != parity_of(sh, par_odd));
                            flags.frm_err <= !rxd;
                            st            <= RX_IDLE;
                        end
                    end else cnt <= cnt + CW'(1);
                    RX_BRK: if (rxd) st <= RX_IDLE;
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // R5: overrun only rises when an unread character was pending
    assert_ovr_pending_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ovr) |-> $past(rdy));

    // R4: the data phase is entered only after a low mid-start sample
    assert_start_mid_R4: assert property (@(posedge clk) disable iff (rst)
        (st == RX_DATA && $past(st) == RX_START) |-> $past(!rxd));

    // R7: a break never hands a character to the host
    assert_brk_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (st == RX_BRK) |=> !$rose(rdy));

endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
    import uart_mode_pkg::*;
#(
    parameter int DATA_W = CHAR_W,
    parameter int OVS    = OVS_RATE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              tx_tick,
    input  logic              rx_tick,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_rdy,
    output logic              tx_empty,
    output logic              rx_rdy,
    output logic              par_err,
    output logic              frm_err,
    output logic              brk_flag,
    output logic              ovr_err,
    input  logic              line_rx,
    output logic              line_tx
);
    chan_mode_e mode_q;
    logic       host_path, is_remote, is_local;
    logic       tx_out, thr_full, tx_busy;
    logic       rx_busy, rx_run, rx_tick_sel, rx_in, rx_rdy_i;
    rx_flags_t  rx_fl;
    logic       echo_q, rem_q;

    always_ff @(posedge clk) begin
        if (rst)                      mode_q <= MODE_NORMAL;
        else if (!tx_busy && !rx_busy) mode_q <= chan_mode_e'(mode_sel);
    end

    assign is_remote   = (mode_q == MODE_REMOTE);
    assign is_local    = (mode_q == MODE_LOCAL);
    assign host_path   = (mode_q == MODE_NORMAL) || is_local;
    assign rx_run      = is_local ? 1'b1 : (is_remote ? 1'b0 : rx_en);
    assign rx_tick_sel = is_local ? tx_tick : rx_tick;
    assign rx_in       = is_local ? tx_out : line_rx;

    uart_tx_core #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tx_tick),
        .en       (tx_en),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .wr       (host_wr && host_path),
        .wdata    (host_wdata),
        .txd      (tx_out),
        .thr_full (thr_full),
        .busy     (tx_busy)
    );

    uart_rx_core #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (rx_tick_sel),
        .run     (rx_run),
        .par_en  (par_en),
        .par_odd (par_odd),
        .rxd     (rx_in),
        .rd      (host_rd && !is_remote),
        .rdy     (rx_rdy_i),
        .data    (rx_data),
        .flags   (rx_fl),
        .busy    (rx_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            echo_q <= 1'b1;
            rem_q  <= 1'b1;
        end else begin
            echo_q <= line_rx;
            if (rx_tick) rem_q <= line_rx;
        end
    end

    always_comb begin
        case (mode_q)
            MODE_ECHO:   line_tx = echo_q;
            MODE_LOCAL:  line_tx = 1'b1;
            MODE_REMOTE: line_tx = rem_q;
            default:     line_tx = tx_out;
        endcase
    end

    assign tx_rdy   = host_path && !thr_full;
    assign tx_empty = host_path && !thr_full && !tx_busy;
    assign rx_rdy   = rx_rdy_i      && !is_remote;
    assign par_err  = rx_fl.par_err && !is_remote;
    assign frm_err  = rx_fl.frm_err && !is_remote;
    assign brk_flag = rx_fl.brk     && !is_remote;
    assign ovr_err  = rx_fl.ovr     && !is_remote;

    // R1: the mode register only moves while both directions are idle
    assert_mode_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> $past(!tx_busy && !rx_busy));

    // R8: echo hides the transmitter from the host
    assert_echo_txstat_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ECHO) |-> (!tx_rdy && !tx_empty));

    // R11: remote loopback reports nothing to the host
    assert_remote_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        is_remote |-> !(rx_rdy || par_err || frm_err || brk_flag || ovr_err || tx_rdy));

endmodule

// File: tb/sim_uart_mode_router.sv
`timescale 1ns/1ps
module sim_uart_mode_router;
    localparam int BIT = 32;   // 16 ticks, one tick every 2 clocks

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'd0;
    logic       tx_en = 1'b1, rx_en = 1'b1, par_en = 1'b0, par_odd = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       line_rx = 1'b1;
    logic [7:0] rx_data;
    logic       tx_rdy, tx_empty, rx_rdy, par_err, frm_err, brk_flag, ovr_err, line_tx;
    logic       tx_tick, rx_tick;
    logic       phase = 1'b0, auto_tx = 1'b1, auto_rx = 1'b1, man_rx = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always @(negedge clk) phase <= ~phase;
    assign tx_tick = auto_tx & phase;
    assign rx_tick = (auto_rx & phase) | man_rx;

    uart_mode_router u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .tx_en(tx_en), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .tx_tick(tx_tick), .rx_tick(rx_tick),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .rx_data(rx_data), .tx_rdy(tx_rdy), .tx_empty(tx_empty), .rx_rdy(rx_rdy),
        .par_err(par_err), .frm_err(frm_err), .brk_flag(brk_flag), .ovr_err(ovr_err),
        .line_rx(line_rx), .line_tx(line_tx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        host_wdata = d;
        host_wr = 1'b1;
        wait_clk(1);
        host_wr = 1'b0;
    endtask

    task automatic host_read();
        host_rd = 1'b1;
        wait_clk(1);
        host_rd = 1'b0;
        wait_clk(1);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_sel = m;
        wait_clk(3);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit use_par, input logic pb, input logic stp);
        line_rx = 1'b0;
        wait_clk(BIT);
        for (int i = 0; i < 8; i++) begin
            line_rx = d[i];
            wait_clk(BIT);
        end
        if (use_par) begin
            line_rx = pb;
            wait_clk(BIT);
        end
        line_rx = stp;
        wait_clk(BIT);
        line_rx = 1'b1;
        wait_clk(4);
    endtask

    task automatic capture_tx(input bit use_par, output logic [7:0] d, output logic pb, output logic stp);
        int to = 0;
        d = 8'h00; pb = 1'b0; stp = 1'b0;
        while (line_tx !== 1'b0 && to < 4000) begin
            wait_clk(1);
            to++;
        end
        chk("R2 start bit seen", int'(line_tx), 0);
        wait_clk(BIT / 2);
        for (int i = 0; i < 8; i++) begin
            wait_clk(BIT);
            d[i] = line_tx;
        end
        if (use_par) begin
            wait_clk(BIT);
            pb = line_tx;
        end
        wait_clk(BIT);
        stp = line_tx;
    endtask

    task automatic t_reset();
        chk("R2 tx_rdy after reset", int'(tx_rdy), 1);
        chk("R2 tx_empty after reset", int'(tx_empty), 1);
        chk("R2 line_tx idle after reset", int'(line_tx), 1);
        chk("R5 rx_rdy after reset", int'(rx_rdy), 0);
    endtask

    task automatic t_normal_tx();
        logic [7:0] d; logic pb, stp;
        host_write(8'hA5);
        chk("R2 tx_rdy drops after write", int'(tx_rdy), 0);
        chk("R2 tx_empty drops after write", int'(tx_empty), 0);
        capture_tx(1'b0, d, pb, stp);
        chk("R2 tx data", int'(d), 8'hA5);
        chk("R2 tx stop bit", int'(stp), 1);
        wait_clk(BIT);
        chk("R2 tx_empty after frame", int'(tx_empty), 1);
    endtask

    task automatic t_parity_tx();
        logic [7:0] d; logic pb, stp;
        par_en = 1'b1; par_odd = 1'b0;
        host_write(8'h07);
        capture_tx(1'b1, d, pb, stp);
        chk("R3 even parity bit for 07", int'(pb), 1);
        wait_clk(BIT);
        par_odd = 1'b1;
        host_write(8'h07);
        capture_tx(1'b1, d, pb, stp);
        chk("R3 odd parity bit for 07", int'(pb), 0);
        chk("R3 stop after parity", int'(stp), 1);
        wait_clk(BIT);
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_rx_basic();
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        chk("R5 rx_rdy after frame", int'(rx_rdy), 1);
        chk("R5 rx_data", int'(rx_data), 8'h3C);
        chk("R6 no framing error", int'(frm_err), 0);
        host_read();
        chk("R5 read clears rx_rdy", int'(rx_rdy), 0);
        send_frame(8'h11, 1'b0, 1'b0, 1'b1);
        send_frame(8'h22, 1'b0, 1'b0, 1'b1);
        chk("R5 overrun set", int'(ovr_err), 1);
        chk("R5 newest data kept", int'(rx_data), 8'h22);
        host_read();
        chk("R5 read clears overrun", int'(ovr_err), 0);
    endtask

    task automatic t_rx_errors();
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h01, 1'b1, 1'b0, 1'b1);
        chk("R3 wrong parity flagged", int'(par_err), 1);
        host_read();
        send_frame(8'h03, 1'b1, 1'b0, 1'b1);
        chk("R3 right parity clean", int'(par_err), 0);
        host_read();
        par_en = 1'b0;
        send_frame(8'h55, 1'b0, 1'b0, 1'b0);
        wait_clk(BIT);
        chk("R6 framing error", int'(frm_err), 1);
        chk("R6 data still delivered", int'(rx_data), 8'h55);
        host_read();
    endtask

    task automatic t_glitch();
        line_rx = 1'b0;
        wait_clk(6);
        line_rx = 1'b1;
        wait_clk(12 * BIT);
        chk("R4 short glitch gives no char", int'(rx_rdy), 0);
        send_frame(8'h81, 1'b0, 1'b0, 1'b1);
        chk("R4 char after glitch", int'(rx_data), 8'h81);
        host_read();
    endtask

    task automatic t_break();
        line_rx = 1'b0;
        wait_clk(12 * BIT);
        chk("R7 break flag", int'(brk_flag), 1);
        chk("R7 no char on break", int'(rx_rdy), 0);
        wait_clk(4 * BIT);
        chk("R7 still no char while low", int'(rx_rdy), 0);
        line_rx = 1'b1;
        wait_clk(4);
        host_read();
        chk("R7 read clears break", int'(brk_flag), 0);
        send_frame(8'h42, 1'b0, 1'b0, 1'b1);
        chk("R7 char after break", int'(rx_data), 8'h42);
        host_read();
    endtask

    task automatic t_mode_gate();
        int to = 0;
        host_write(8'h5A);
        while (line_tx !== 1'b0 && to < 4000) begin
            wait_clk(1);
            to++;
        end
        wait_clk(40);
        mode_sel = 2'd1;
        wait_clk(5);
        chk("R1 mode held while transmitting", int'(tx_rdy), 1);
        wait_clk(11 * BIT);
        chk("R1 echo active after idle", int'(tx_rdy), 0);
    endtask

    task automatic t_echo();
        chk("R8 tx_empty inactive", int'(tx_empty), 0);
        line_rx = 1'b0;
        wait_clk(1);
        chk("R8 line follows low", int'(line_tx), 0);
        line_rx = 1'b1;
        wait_clk(1);
        chk("R8 line follows high", int'(line_tx), 1);
        wait_clk(BIT);
        host_write(8'h77);
        chk("R8 write ignored tx_rdy", int'(tx_rdy), 0);
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h5A, 1'b1, 1'b1, 1'b1);
        chk("R9 echo delivers char", int'(rx_data), 8'h5A);
        chk("R9 echo checks parity", int'(par_err), 1);
        host_read();
        par_en = 1'b0;
        line_rx = 1'b0;
        wait_clk(12 * BIT);
        chk("R8 break passed through", int'(line_tx), 0);
        chk("R9 echo reports break", int'(brk_flag), 1);
        line_rx = 1'b1;
        wait_clk(4);
        chk("R8 line back to mark", int'(line_tx), 1);
        host_read();
        set_mode(2'd0);
        chk("R8 write in echo not loaded", int'(tx_empty), 1);
    endtask

    task automatic t_local();
        rx_en = 1'b0; auto_rx = 1'b0;
        set_mode(2'd2);
        line_rx = 1'b0;
        wait_clk(2);
        chk("R10 line_tx held mark", int'(line_tx), 1);
        host_write(8'h96);
        wait_clk(12 * BIT);
        chk("R10 looped char ready", int'(rx_rdy), 1);
        chk("R10 looped data", int'(rx_data), 8'h96);
        chk("R10 line_tx still mark", int'(line_tx), 1);
        host_read();
        tx_en = 1'b0;
        host_write(8'h3C);
        wait_clk(12 * BIT);
        chk("R10 nothing while tx disabled", int'(rx_rdy), 0);
        tx_en = 1'b1;
        wait_clk(12 * BIT);
        chk("R10 loops after tx enabled", int'(rx_data), 8'h3C);
        host_read();
        line_rx = 1'b1; rx_en = 1'b1; auto_rx = 1'b1;
        wait_clk(4);
        set_mode(2'd0);
    endtask

    task automatic t_remote();
        auto_rx = 1'b0;
        set_mode(2'd3);
        chk("R11 tx_rdy inactive", int'(tx_rdy), 0);
        line_rx = 1'b0;
        wait_clk(3);
        chk("R11 no copy without tick", int'(line_tx), 1);
        man_rx = 1'b1;
        wait_clk(1);
        man_rx = 1'b0;
        chk("R11 copy on rx tick", int'(line_tx), 0);
        line_rx = 1'b1;
        man_rx = 1'b1;
        wait_clk(1);
        man_rx = 1'b0;
        chk("R11 copy high on rx tick", int'(line_tx), 1);
        auto_rx = 1'b1;
        send_frame(8'h24, 1'b0, 1'b0, 1'b1);
        chk("R11 frame not delivered", int'(rx_rdy), 0);
        host_write(8'h11);
        set_mode(2'd0);
        chk("R11 host write ignored", int'(tx_empty), 1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1..R11 run) actual=timeout expected=finish");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_normal_tx();
        t_parity_tx();
        t_rx_basic();
        t_rx_errors();
        t_glitch();
        t_break();
        t_mode_gate();
        t_echo();
        t_local();
        t_remote();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule